// File: doc/BRIEF.md
# Shadowed Nonvolatile Configuration Register

This block holds a 16-bit configuration word as a fast volatile working copy with a nonvolatile shadow copy behind it, bit for bit. Next to it sits a 16-bit volatile control word. A decoded command interface delivers one command per cycle: an opcode, an address and data. A power-up pulse reloads the working configuration copy from the shadow. The working copy takes any number of writes. The shadow is written only when a general EEPROM write arrives while the write-enable latch is set. That write is a side effect: its own address and data are never looked at, and the shadow simply takes the current working copy.

Each store starts a modelled nonvolatile write cycle lasting `NV_CYCLES` clocks. While it runs, the block reports busy and drops every command. The shadow contents and a store counter are brought out so the nonvolatile side can be watched.

Top module: `shadow_cfg_reg`

## Requirements
- R1: During reset, `cfg_q` and `shadow_q` take `SHADOW_INIT` with its fixed bits forced to zero. `ctrl_q`, `busy`, `wel_q` and `store_cnt` are all zero.
- R2: A write-config command (opcode 0) that is accepted loads `cmd_data` into `cfg_q`, with the fixed bits forced to zero, at the next clock edge. `shadow_q` does not change.
- R3: Bit 15 is the cell-count selector and always reads 0, which selects three-cell operation. Bits 7:0 are unused and always read 0. Only bits 14:8 can be written, in both `cfg_q` and `shadow_q`.
- R4: A write-enable command (opcode 2) sets `wel_q`. A later general EEPROM write (opcode 3) copies `cfg_q` into `shadow_q` at the edge that accepts it. The store does not depend on `cmd_addr` or `cmd_data`.
- R5: A general EEPROM write while `wel_q` is 0 does not store. `shadow_q`, `busy` and `store_cnt` stay as they were.
- R6: Any accepted general EEPROM write clears `wel_q`, and so does `pwr_up`. Each store therefore needs a fresh write-enable.
- R7: After a store, `busy` is 1 for exactly `NV_CYCLES` cycles, starting the cycle after the store. Every command presented on those edges is ignored.
- R8: `pwr_up` loads `shadow_q` into `cfg_q`, which discards unstored writes. It also clears `ctrl_q`, clears `wel_q` and ends a write cycle that is running. Commands in that same cycle are ignored.
- R9: A write-control command (opcode 1) loads all 16 bits of `cmd_data` into `ctrl_q`. `pwr_up` or `sleep_exit` clears `ctrl_q` to 0x0000, and the clear wins over a write in the same cycle.
- R10: `store_cnt` goes up by one for each store and wraps modulo 2^`CNT_W`. Working-copy writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up | input | 1 | Power-up pulse: recall from the shadow |
| sleep_exit | input | 1 | Sleep-exit pulse: clears the control word |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 0 write-config, 1 write-control, 2 write-enable, 3 EEPROM write |
| cmd_addr | input | ADDR_W | Command address (ignored by the store) |
| cmd_data | input | DATA_W | Command data |
| cfg_q | output | DATA_W | Working configuration copy |
| ctrl_q | output | DATA_W | Control word |
| shadow_q | output | DATA_W | Nonvolatile shadow (debug view) |
| busy | output | 1 | Nonvolatile write cycle in progress |
| wel_q | output | 1 | Write-enable latch |
| store_cnt | output | CNT_W | Number of shadow stores |

## Verification
Every register result appears one clock edge after the command or pulse that causes it. The one exception is `busy`: it rises one edge after a store and falls `NV_CYCLES` edges after that. The bench applies each stimulus just after a falling edge and lets one rising edge pass. It then compares all six outputs at the next falling edge against a model built from the requirements. During a write cycle it keeps presenting commands, so that the model's busy window and the design's dropping of commands are checked on every edge of that window.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  typedef enum logic [1:0] {
    OP_WR_CFG  = 2'd0,
    OP_WR_CTRL = 2'd1,
    OP_WR_EN   = 2'd2,
    OP_EE_WR   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/cfgreg_ctrl_reg.sv
module cfgreg_ctrl_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) q <= '0;
    else if (wr)      q <= din;
  end

  // R9: a clear pulse leaves the control word at zero
  p_ctrl_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> q == '0);
  // R9: a write without a clear takes the data
  p_ctrl_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && !clear) |=> q == $past(din));
endmodule

// File: rtl/cfgreg_nv_store.sv
module cfgreg_nv_store #(
  parameter int              DATA_W    = 16,
  parameter int              NV_CYCLES = 8,
  parameter int              CNT_W     = 16,
  parameter logic [DATA_W-1:0] INIT    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up,
  input  logic              store_go,
  input  logic [DATA_W-1:0] cfg_in,
  output logic [DATA_W-1:0] shadow_q,
  output logic              busy,
  output logic [CNT_W-1:0]  store_cnt
);
  localparam int TMR_W = $clog2(NV_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(NV_CYCLES);

  logic [TMR_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= INIT;
      tmr       <= '0;
      store_cnt <= '0;
    end else if (pwr_up) begin
      tmr <= '0;
    end else if (store_go) begin
      shadow_q  <= cfg_in;
      tmr       <= TMR_LOAD;
      store_cnt <= store_cnt + 1'b1;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign busy = (tmr != '0);

  // R2 R5: shadow only moves on a store
  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !store_go |=> $stable(shadow_q));
  // R7 R10: a store raises busy and counts once
  p_store_busy_r7: assert property (@(posedge clk) disable iff (rst)
    store_go |=> busy && store_cnt == $past(store_cnt) + 1'b1);
  // R7: no store is requested while a write cycle runs
  p_no_store_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !store_go);
endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg
  import cfgreg_pkg::*;
#(
  parameter int              DATA_W      = 16,
  parameter int              ADDR_W      = 9,
  parameter int              NV_CYCLES   = 8,
  parameter int              CNT_W       = 16,
  parameter int              CELL_BIT    = DATA_W - 1,
  parameter logic [DATA_W-1:0] SHADOW_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up,
  input  logic              sleep_exit,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] shadow_q,
  output logic              busy,
  output logic              wel_q,
  output logic [CNT_W-1:0]  store_cnt
);
  localparam int HALF = DATA_W / 2;

  // writable-bit mask: upper half minus the cell-count selector
  function automatic logic [DATA_W-1:0] mk_mask();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= HALF) && (i != CELL_BIT);
    return m;
  endfunction
  localparam logic [DATA_W-1:0] WMASK = mk_mask();
  localparam logic [DATA_W-1:0] INIT_M = SHADOW_INIT & WMASK;

  cfg_op_e op;
  logic    accept, wr_cfg, wr_ctrl, wr_en, ee_any, store_go, busy_i;
  logic    addr_unused;

  assign op          = cfg_op_e'(cmd_op);
  assign addr_unused = ^cmd_addr;  // the store never decodes the address
  assign accept      = cmd_valid && !pwr_up && !busy_i;
  assign wr_cfg      = accept && (op == OP_WR_CFG);
  assign wr_ctrl     = accept && (op == OP_WR_CTRL);
  assign wr_en       = accept && (op == OP_WR_EN);
  assign ee_any      = accept && (op == OP_EE_WR);
  assign store_go    = ee_any && wel_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= INIT_M;
    else if (pwr_up) cfg_q <= shadow_q;
    else if (wr_cfg) cfg_q <= cmd_data & WMASK;
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_up) wel_q <= 1'b0;
    else if (ee_any)   wel_q <= 1'b0;
    else if (wr_en)    wel_q <= 1'b1;
  end

  cfgreg_nv_store #(
    .DATA_W(DATA_W), .NV_CYCLES(NV_CYCLES), .CNT_W(CNT_W), .INIT(INIT_M)
  ) u_nv (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .store_go(store_go),
    .cfg_in(cfg_q), .shadow_q(shadow_q), .busy(busy_i), .store_cnt(store_cnt)
  );

  cfgreg_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .clear(pwr_up || sleep_exit), .wr(wr_ctrl),
    .din(cmd_data), .q(ctrl_q)
  );

  assign busy = busy_i;

  // R8: power-up recalls the shadow
  p_recall_r8: assert property (@(posedge clk) disable iff (rst)
    pwr_up |=> cfg_q == $past(shadow_q));
  // R2: accepted write lands in the working copy
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> cfg_q == ($past(cmd_data) & WMASK));
  // R6: latch clears after an EEPROM write or power-up
  p_wel_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ee_any || pwr_up) |=> !wel_q);
  // R3: fixed bits of the shadow stay zero
  p_fixed_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (shadow_q & ~WMASK) == '0);
  // R4: a store copies the working copy
  p_store_copy_r4: assert property (@(posedge clk) disable iff (rst)
    store_go |=> shadow_q == $past(cfg_q));
endmodule

// File: tb/shadow_cfg_reg_test.sv
module shadow_cfg_reg_test;
  localparam int CLK_P = 10;
  localparam int NV = 4;
  localparam logic [15:0] INIT = 16'h2A00;
  localparam logic [15:0] M = 16'h7F00;

  logic clk = 0, rst = 1, pwr_up = 0, sleep_exit = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [8:0] cmd_addr = 0;
  logic [15:0] cmd_data = 0;
  logic [15:0] cfg_q, ctrl_q, shadow_q, store_cnt;
  logic busy, wel_q;

  int checks = 0, fails = 0;
  logic [15:0] mcfg, mctrl, msh, mcnt;
  logic mwel;
  int mb;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  shadow_cfg_reg #(.NV_CYCLES(NV), .SHADOW_INIT(INIT)) uut (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .sleep_exit(sleep_exit),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cfg_q(cfg_q), .ctrl_q(ctrl_q), .shadow_q(shadow_q),
    .busy(busy), .wel_q(wel_q), .store_cnt(store_cnt));

  task automatic chk(input string tag, input string nm, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, nm, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "cfg_q", cfg_q, mcfg);
    chk(tag, "ctrl_q", ctrl_q, mctrl);
    chk(tag, "shadow_q", shadow_q, msh);
    chk(tag, "store_cnt", store_cnt, mcnt);
    chk(tag, "busy", {15'd0, busy}, {15'd0, mb != 0});
    chk(tag, "wel_q", {15'd0, wel_q}, {15'd0, mwel});
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [8:0] a,
                      input logic [15:0] d, input logic pu, input logic se, input string tag);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_data = d;
    pwr_up = pu; sleep_exit = se;
    @(posedge clk);
    if (pu) begin mcfg = msh; mctrl = 0; mwel = 0; mb = 0; end
    else if (mb != 0) mb--;
    else if (v) begin
      case (op)
        2'd0: mcfg = d & M;
        2'd1: mctrl = d;
        2'd2: mwel = 1;
        default: begin
          if (mwel) begin msh = mcfg; mb = NV; mcnt++; end
          mwel = 0;
        end
      endcase
    end
    if (se) mctrl = 0;
    @(negedge clk);
    cmd_valid = 0; pwr_up = 0; sleep_exit = 0;
    chk_all(tag);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [15:0] d, input string tag);
    step(1, op, 9'h0, d, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    mcfg = INIT; msh = INIT; mctrl = 0; mcnt = 0; mwel = 0; mb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_all("R1 reset");
    rst = 0;
    @(negedge clk);
    chk_all("R1 after reset");

    // R2 R3: sweep every upper-byte pattern with varied lower bytes
    for (int v = 0; v < 256; v++) begin
      cmd(2'd0, {v[7:0], v[7:0] ^ 8'hA5}, "R2 R3 cfg sweep");
      chk("R3", "cell bit", {15'd0, cfg_q[15]}, 16'd0);
    end

    // R9: control word writes and clears
    for (int v = 0; v < 16; v++) cmd(2'd1, 16'h1111 * v[15:0] ^ 16'h8001, "R9 ctrl write");
    step(0, 2'd0, 0, 0, 0, 1, "R9 sleep clear");
    cmd(2'd1, 16'hBEEF, "R9 ctrl write");
    step(1, 2'd1, 0, 16'h1234, 0, 1, "R9 clear wins");

    // R5: EEPROM write without enable
    cmd(2'd0, 16'h5500, "R2 setup");
    cmd(2'd3, 16'hFFFF, "R5 no enable");
    cmd(2'd3, 16'h0000, "R5 no enable again");

    // R4 R7 R10 R6: stores with varied addr/data, commands during busy
    for (int s = 0; s < 12; s++) begin
      cmd(2'd0, {s[7:0] * 8'd23, 8'h3C}, "R2 pre-store");
      cmd(2'd2, 16'h0, "R4 write enable");
      step(1, 2'd3, 9'(s * 37), 16'(s * 4099), 0, 0, "R4 R10 store");
      for (int b = 0; b < NV; b++)
        step(1, 2'(b), 9'h1FF, 16'hFFFF, 0, 0, "R7 busy ignore");
      cmd(2'd3, 16'h0, "R6 no fresh enable");
      for (int b = 0; b < NV; b++) step(0, 2'd0, 0, 0, 0, 0, "R7 idle");
    end

    // R6 R8: enable then power-up clears latch
    cmd(2'd2, 16'h0, "R6 enable");
    step(0, 2'd0, 0, 0, 1, 0, "R8 R6 power-up");
    cmd(2'd3, 16'h0, "R6 after power-up");

    // R8: unstored write discarded by power cycle, ctrl cleared
    cmd(2'd0, 16'h7F00, "R2 unstored");
    cmd(2'd1, 16'hCAFE, "R9 ctrl");
    step(1, 2'd0, 0, 16'h0100, 1, 0, "R8 recall ignores cmd");

    // R8: power-up during a write cycle ends it
    cmd(2'd0, 16'h4400, "R2 pre-store");
    cmd(2'd2, 16'h0, "R4 enable");
    cmd(2'd3, 16'h0, "R4 R10 store");
    step(0, 2'd0, 0, 0, 1, 0, "R8 abort busy");
    cmd(2'd0, 16'h1200, "R7 accepted after abort");

    finish_run();
  end
endmodule